// File: doc/BRIEF.md
# SCL Stretch Watchdog Timer

This block watches for a target that holds the I2C clock line low for too long. The bus engine asserts `stretch_i` while it wants SCL released but sees it low. While the timer is enabled, each clock cycle with `stretch_i` high advances a power-of-two prescaler. Each prescaler wrap advances a 15-bit count. When the count reaches the programmed limit, a sticky timeout flag is set. The flag stays set until software clears it. It drives the interrupt line only while its enable is set.

Software programs two settings. The first is a control word that holds the enable bit next to the limit. Software can turn the timer off and on around a command start by rewriting only the enable bit, and the limit is kept. The second is a small exponent register that picks how many input clocks make one timer tick. No data streams through the block. All pins are plain control and status levels or one-cycle strobes, so there is no valid/ready handshake and no back-pressure.

Top module: `scl_wait_timer`

## Requirements
- R1: After reset the timeout flag and the interrupt are low, the control word reads 0 (disabled, limit 0), and the exponent reads 0.
- R2: The control word has the enable in bit 15 and the limit in bits 14:0. The readback shows the last value written. A write with bit 15 clear stops the timer, and the limit field still reads back unchanged.
- R3: Let the exponent be N (4 bits, range 0 to 15) and the limit be L. The flag sets after exactly L*2^N consecutive rising edges with `stretch_i` high and the timer enabled. After L*2^N-1 such edges it does not set.
- R4: A single cycle with `stretch_i` low returns both the prescaler and the count to zero. Only one unbroken low period is timed.
- R5: While the enable bit is clear, the flag never sets, however long `stretch_i` stays high.
- R6: Enabling the timer, or enabling it again after a disable, always gives a full period. The first edge counted is the one after the edge that loads the enable, even when a partial count existed before the disable.
- R7: One continuous stretch period produces at most one expiry. Clearing the flag while the stretch continues does not set it again.
- R8: The flag holds until a cycle with `clr_i` high clears it. `tmo_irq_o` is high exactly when the flag is high and `ien_i` is high.
- R9: When `clr_i` and an expiry fall in the same cycle, the flag ends up set.
- R10: A limit of 0 never expires.
- R11: The exponent register takes `div_wdata` on a `div_wr` strobe and reads it back on `div_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data: bit 15 enable, bits 14:0 limit |
| div_wr | input | 1 | Exponent register write strobe |
| div_wdata | input | 4 | Prescale exponent N; one tick every 2^N clocks |
| cfg_o | output | 16 | Control word readback |
| div_o | output | 4 | Exponent readback |
| stretch_i | input | 1 | SCL held low while the master wants it high |
| clr_i | input | 1 | Clear strobe for the timeout flag |
| ien_i | input | 1 | Interrupt enable for the timeout flag |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| tmo_irq_o | output | 1 | Timeout flag gated by its interrupt enable |

## Verification
The two functions that can meet in one cycle are the expiry that sets the flag and the software clear that drops it. The bench starts a stretch of known length and pulses `clr_i` so that it is sampled on the very edge that completes the count. It then checks that the flag is still high afterwards. A second collision comes from disabling and enabling the timer in the middle of a stretch. There the bench checks that the expiry moves to one full period after the new enable, not to the remainder of the old count.

// File: rtl/scl_wd_pkg.sv
package scl_wd_pkg;
  localparam int DEF_LIM_W = 15;
  localparam int DEF_EXP_W = 4;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_DONE = 2'd2
  } wd_state_e;
endpackage

// File: rtl/scl_wd_regs.sv
module scl_wd_regs #(
  parameter int LIM_W = scl_wd_pkg::DEF_LIM_W,
  parameter int EXP_W = scl_wd_pkg::DEF_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [LIM_W:0]   ctl_wdata,
  input  logic             div_wr,
  input  logic [EXP_W-1:0] div_wdata,
  output logic             en_o,
  output logic [LIM_W-1:0] lim_o,
  output logic [EXP_W-1:0] exp_o
);
  logic             en_q;
  logic [LIM_W-1:0] lim_q;
  logic [EXP_W-1:0] exp_q;

  // enable and limit share one word; a write always loads both
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lim_q <= '0;
      exp_q <= '0;
    end else begin
      if (ctl_wr) begin
        en_q  <= ctl_wdata[LIM_W];
        lim_q <= ctl_wdata[LIM_W-1:0];
      end
      if (div_wr) exp_q <= div_wdata;
    end
  end

  assign en_o  = en_q;
  assign lim_o = lim_q;
  assign exp_o = exp_q;
endmodule

// File: rtl/scl_wd_prescale.sv
module scl_wd_prescale #(
  parameter int EXP_W = scl_wd_pkg::DEF_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PW = (1 << EXP_W) - 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  // exponent N gives a mask of N ones; the counter wraps at the mask
  assign mask   = PW'({PW{1'b1}} >> (PW - int'(exp_i)));
  assign tick_o = run_i && (pre_q == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || tick_o) pre_q <= '0;
    else                            pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/scl_wd_count.sv
module scl_wd_count #(
  parameter int LIM_W = scl_wd_pkg::DEF_LIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             expire_o
);
  import scl_wd_pkg::*;

  wd_state_e        st_q;
  logic [LIM_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (lim_i != '0) && (cnt_q == lim_i - 1'b1);
  assign expire_o = run_i && tick_i && (st_q != WD_DONE) && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      st_q  <= WD_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        WD_IDLE, WD_RUN: begin
          if (expire_o) begin
            st_q <= WD_DONE;
          end else begin
            st_q <= WD_RUN;
            if (tick_i) cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= WD_DONE;
      endcase
    end
  end
endmodule

// File: rtl/scl_wd_status.sv
module scl_wd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // a new expiry outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ien_i;
endmodule

// File: rtl/scl_wait_timer.sv
module scl_wait_timer #(
  parameter int LIM_W = scl_wd_pkg::DEF_LIM_W,
  parameter int EXP_W = scl_wd_pkg::DEF_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [LIM_W:0]   ctl_wdata,
  input  logic             div_wr,
  input  logic [EXP_W-1:0] div_wdata,
  output logic [LIM_W:0]   cfg_o,
  output logic [EXP_W-1:0] div_o,
  input  logic             stretch_i,
  input  logic             clr_i,
  input  logic             ien_i,
  output logic             tmo_flag_o,
  output logic             tmo_irq_o
);
  logic             en;
  logic [LIM_W-1:0] lim;
  logic [EXP_W-1:0] expn;
  logic             run;
  logic             tick;
  logic             expire;

  scl_wd_regs #(.LIM_W(LIM_W), .EXP_W(EXP_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata),
    .en_o(en), .lim_o(lim), .exp_o(expn)
  );

  // disable or release both zero the prescaler and the count
  assign run = en && stretch_i;

  scl_wd_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .exp_i(expn), .tick_o(tick)
  );

  scl_wd_count #(.LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
    .lim_i(lim), .expire_o(expire)
  );

  scl_wd_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .clr_i(clr_i),
    .ien_i(ien_i), .flag_o(tmo_flag_o), .irq_o(tmo_irq_o)
  );

  assign cfg_o = {en, lim};
  assign div_o = expn;
endmodule

// File: rtl/scl_wait_timer_chk.sv
module scl_wait_timer_chk #(
  parameter int LIM_W = scl_wd_pkg::DEF_LIM_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_i,
  input logic           stretch_i,
  input logic [LIM_W:0] cfg_o,
  input logic           tmo_flag_o,
  input logic           run,
  input logic           tick,
  input logic           expire
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag_o && !clr_i |=> tmo_flag_o); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    expire && clr_i |=> tmo_flag_o); // R9
  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> $past(cfg_o[LIM_W]) && $past(stretch_i)); // R5
  AST_RISE_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> $past(cfg_o[LIM_W-1:0]) != '0); // R10
  AST_TICK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R4
  AST_ONE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R7
endmodule

bind scl_wait_timer scl_wait_timer_chk #(.LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .stretch_i(stretch_i),
  .cfg_o(cfg_o), .tmo_flag_o(tmo_flag_o), .run(run), .tick(tick),
  .expire(expire)
);

// File: tb/tb_scl_wait_timer.sv
module tb_scl_wait_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        div_wr = 1'b0;
  logic [3:0]  div_wdata = '0;
  logic [15:0] cfg_o;
  logic [3:0]  div_o;
  logic        stretch_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        ien_i = 1'b0;
  logic        tmo_flag_o;
  logic        tmo_irq_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_q[$];
  logic flag_prev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scl_wait_timer dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .cfg_o(cfg_o), .div_o(div_o),
    .stretch_i(stretch_i), .clr_i(clr_i), .ien_i(ien_i),
    .tmo_flag_o(tmo_flag_o), .tmo_irq_o(tmo_irq_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: every flag rise is popped against the scoreboard
  always @(negedge clk) begin
    if (rst_n && tmo_flag_o && !flag_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected expiry", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R3 expiry cycle", cyc, e);
      end
    end
    flag_prev = tmo_flag_o;
  end

  task automatic wr_ctl(input bit en, input int lim, output int at);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {en, 15'(lim)}; at = cyc;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_div(input int n);
    @(negedge clk);
    div_wr = 1'b1; div_wdata = 4'(n);
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  // driver: holds the stretch for len cycles and pushes the expected expiry
  task automatic low_period(input int lim, input int n, input int len, input string req);
    int s;
    @(negedge clk);
    stretch_i = 1'b1; s = cyc;
    if (lim != 0 && (lim << n) <= len) exp_q.push_back(s + (lim << n));
    repeat (len) @(negedge clk);
    stretch_i = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, {req, " expiry missing"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic clear_flag();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tmo_flag_o == 0 && tmo_irq_o == 0, "R1 flag/irq at reset", tmo_flag_o, 0);
    chk(cfg_o == 16'h0, "R1 control at reset", cfg_o, 0);
    chk(div_o == 4'h0, "R1 exponent at reset", div_o, 0);

    // R3 basic, N=0
    wr_ctl(1'b1, 5, t);
    chk(cfg_o == 16'h8005, "R2 control readback", cfg_o, 16'h8005);
    low_period(5, 0, 9, "R3 L5 N0");
    chk(tmo_flag_o == 1, "R8 flag holds after release", tmo_flag_o, 1);
    clear_flag();
    chk(tmo_flag_o == 0, "R8 clear drops flag", tmo_flag_o, 0);

    // R3 with prescale, R11 readback
    wr_div(2);
    chk(div_o == 4'd2, "R11 exponent readback", div_o, 2);
    wr_ctl(1'b1, 3, t);
    low_period(3, 2, 15, "R3 L3 N2");
    clear_flag();

    // R3 one short of the period, then R4 restart after release
    wr_div(1);
    wr_ctl(1'b1, 4, t);
    low_period(4, 1, 7, "R3 short by one");
    chk(tmo_flag_o == 0, "R3 no expiry one edge early", tmo_flag_o, 0);
    low_period(4, 1, 8, "R4 fresh low period");
    clear_flag();

    // R5 disabled keeps the limit and never fires
    wr_div(0);
    wr_ctl(1'b0, 2, t);
    chk(cfg_o == 16'h0002, "R2 limit kept while disabled", cfg_o, 2);
    low_period(0, 0, 20, "R5 disabled");
    chk(tmo_flag_o == 0, "R5 no expiry while disabled", tmo_flag_o, 0);

    // R6 disable mid-count, re-enable gives a full period
    wr_div(2);
    @(negedge clk); stretch_i = 1'b1;
    wr_ctl(1'b1, 2, t);
    repeat (4) @(negedge clk);
    wr_ctl(1'b0, 2, t);
    wr_ctl(1'b1, 2, t);
    exp_q.push_back(t + 1 + 8);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R6 full period after re-enable", exp_q.size(), 0);
    exp_q.delete();
    stretch_i = 1'b0;

    // R8 interrupt gating while the flag is set
    ien_i = 1'b1;
    @(negedge clk);
    chk(tmo_irq_o == 1, "R8 irq with enable", tmo_irq_o, 1);
    ien_i = 1'b0;
    @(negedge clk);
    chk(tmo_irq_o == 0 && tmo_flag_o == 1, "R8 irq masked", tmo_irq_o, 0);
    clear_flag();

    // R7 one expiry per low period, cleared mid-stretch
    wr_div(0);
    wr_ctl(1'b1, 2, t);
    @(negedge clk); stretch_i = 1'b1; t = cyc;
    exp_q.push_back(t + 2);
    repeat (3) @(negedge clk);
    clear_flag();
    repeat (10) @(negedge clk);
    chk(tmo_flag_o == 0, "R7 no second expiry", tmo_flag_o, 0);
    stretch_i = 1'b0;
    exp_q.delete();

    // R9 clear and expiry in the same cycle
    wr_ctl(1'b1, 3, t);
    @(negedge clk); stretch_i = 1'b1; t = cyc;
    exp_q.push_back(t + 3);
    repeat (2) @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    @(negedge clk);
    chk(tmo_flag_o == 1, "R9 set wins over clear", tmo_flag_o, 1);
    stretch_i = 1'b0;
    clear_flag();
    exp_q.delete();

    // R10 limit zero
    wr_ctl(1'b1, 0, t);
    low_period(0, 0, 40, "R10 zero limit");
    chk(tmo_flag_o == 0, "R10 zero limit never fires", tmo_flag_o, 0);

    // R3 boundaries: largest limit, largest exponent
    wr_ctl(1'b1, 32767, t);
    low_period(32767, 0, 32768, "R3 max limit");
    clear_flag();
    wr_div(15);
    chk(div_o == 4'd15, "R11 max exponent readback", div_o, 15);
    wr_ctl(1'b1, 1, t);
    low_period(1, 15, 32769, "R3 max exponent");
    clear_flag();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule